// File: doc/BRIEF.md
# Microcoded Control Word Unit

This block sequences a small accumulator CPU. An internal phase counter steps through sixteen timing phases. Each phase lasts a fixed number of clock cycles. The counter's value is joined below the current opcode to form a microcode address. The addressed 16-bit word is read from an internal microcode store. That store is built as two independent 8-bit halves and is loaded through a write port with per-half byte enables.

The word is split into two kinds of field:
- Four independent single-bit lines: early phase return, address-source select, program counter increment and latch-pulse request.
- Four 3-bit banks, each decoded into seven one-hot strobes. Code zero and any code marked unused raise no strobe.

An asynchronous reset puts the unit into boot mode. In boot mode the opcode is forced to zero, so the boot microroutine runs from the lowest sixteen words. Boot mode ends only when a release request meets the end of a pass, at the moment the phase returns to zero.

Top module: `ucw_ctrl_unit`

## Requirements
- R1: A write with wr_be[1] set stores wr_data[15:8] into the high half, and one with wr_be[0] set stores wr_data[7:0] into the low half. A half whose enable is clear keeps its old contents. ctrl_word_o shows {high, low} of the addressed word, read without delay, so a full write of 0xBEEF reads back as 0xBEEF.
- R2: ucode_addr_o equals {effective opcode, phase}, and ctrl_word_o is the stored word at that address in the same cycle.
- R3: Each phase lasts CYC_PER_PHASE clock cycles. At the end of the last cycle the phase increments, and it wraps from 15 to 0.
- R4: When bit 15 (early_adv_o) is set in the last cycle of a phase, the next phase is 0 whatever the current phase.
- R5: addr_src_pc_o follows bit 14 and pc_incr_o follows bit 13 of the current word.
- R6: latch_pulse_o is high only in the first cycle of a phase, and only when bit 12 of the current word is set.
- R7: ALU bank, bits 11:9. Code c in 1..7 raises alu_sel_o[c-1] alone (1 pass accumulator, 2 add, 3 subtract, 4 and, 5 or, 6 xor, 7 instruction register load). Code 0 raises none.
- R8: Control bank, bits 8:6. Codes 1 (PC clear), 2 (PC preset), 4 (data register drive), 5 (system halt) and 6 (output register load) raise sys_sel_o[c-1] alone. Codes 0, 3 and 7 raise nothing.
- R9: Memory bank, bits 5:3. Code c in 1..7 raises mem_sel_o[c-1] alone (1 ROM drive, 2 RAM drive, 3 RAM write, 4 address low load, 5 address high load, 6 address load, 7 output register drive). Code 0 raises none.
- R10: Register bank, bits 2:0. Code c in 1..7 raises reg_sel_o[c-1] alone (1 A load, 2 B load, 3 C load, 4 A drive, 5 B drive, 6 C drive, 7 data register load). Code 0 raises none.
- R11: While boot_mode_o is high, the opcode field of the address is zero whatever opcode_in holds.
- R12: Boot mode clears only on a clock edge where boot_release is high and the phase returns to 0, by wrap or by early return. A release at any other edge is ignored.
- R13: While rst_n is low, phase_o is 0, boot_mode_o is 1 and the unit is in the first cycle of a phase. rst_n is asynchronous.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; enters boot mode |
| opcode_in | input | OPC_W | Opcode from the instruction register |
| boot_release | input | 1 | Request to leave boot mode at the next pass boundary |
| wr_en | input | 1 | Microcode store write strobe |
| wr_addr | input | OPC_W+PH_W | Microcode store write address |
| wr_data | input | 16 | Word to write |
| wr_be | input | 2 | Half enables: bit 1 high half, bit 0 low half |
| phase_o | output | PH_W | Current phase |
| ucode_addr_o | output | OPC_W+PH_W | Current microcode address |
| ctrl_word_o | output | 16 | Current control word |
| boot_mode_o | output | 1 | Boot mode active |
| early_adv_o | output | 1 | Bit 15: return to phase 0 at phase end |
| addr_src_pc_o | output | 1 | Bit 14: address source select |
| pc_incr_o | output | 1 | Bit 13: program counter increment |
| latch_pulse_o | output | 1 | One-cycle latch pulse at phase start |
| alu_sel_o | output | 7 | ALU bank strobes |
| sys_sel_o | output | 7 | Control bank strobes |
| mem_sel_o | output | 7 | Memory bank strobes |
| reg_sel_o | output | 7 | Register bank strobes |

## Verification
The boot release and the early phase return can fall on the same clock edge. At that edge the release must take effect, and the next opcode must drive the address from phase 0. The bench provokes this by writing a boot word with bit 15 set at phase 4, then holding boot_release high across that phase and the cycles around it. It judges the result by checking that boot_mode_o and the opcode field of ucode_addr_o change at exactly that edge and at no earlier one. A plain wrap from phase 15 with release held, and a release held in the middle of a phase, are judged the same way.

// File: rtl/ucw_pkg.sv
package ucw_pkg;
  localparam int BYTE_W = 8;
  localparam int WORD_W = 16;
  localparam int HALVES = WORD_W / BYTE_W;
  localparam int BANK_W = 3;
  localparam int STB_W  = (1 << BANK_W) - 1;

  // Field layout of the control word, most significant first.
  typedef struct packed {
    logic              early_adv;
    logic              addr_src_pc;
    logic              pc_incr;
    logic              latch_req;
    logic [BANK_W-1:0] alu;
    logic [BANK_W-1:0] sys;
    logic [BANK_W-1:0] mem;
    logic [BANK_W-1:0] rg;
  } cword_t;

  // Strobe masks: bit i enables code i+1.
  localparam logic [STB_W-1:0] ALL_USED = '1;
  localparam logic [STB_W-1:0] SYS_USED = 7'b0111011;
endpackage

// File: rtl/ucw_store.sv
module ucw_store
  import ucw_pkg::*;
#(
  parameter int AW = 10
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [AW-1:0]     wr_addr,
  input  logic [WORD_W-1:0] wr_data,
  input  logic [HALVES-1:0] wr_be,
  input  logic [AW-1:0]     rd_addr,
  output logic [WORD_W-1:0] rd_word
);
  localparam int DEPTH = 1 << AW;

  for (genvar h = 0; h < HALVES; h++) begin : g_half
    logic [BYTE_W-1:0] bank [DEPTH];
    logic              wen;

    assign wen = wr_en & wr_be[h];

    always_ff @(posedge clk) begin
      if (wen) bank[wr_addr] <= wr_data[h*BYTE_W +: BYTE_W];
    end

    assign rd_word[h*BYTE_W +: BYTE_W] = bank[rd_addr];
  end
endmodule

// File: rtl/ucw_phase_seq.sv
module ucw_phase_seq #(
  parameter int PH_W          = 4,
  parameter int CYC_PER_PHASE = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            early_adv,
  input  logic            boot_release,
  output logic [PH_W-1:0] phase,
  output logic            first_cyc,
  output logic            boot_mode
);
  localparam int              SUB_W   = (CYC_PER_PHASE > 1) ? $clog2(CYC_PER_PHASE) : 1;
  localparam logic [SUB_W-1:0] SUB_LAST = SUB_W'(CYC_PER_PHASE - 1);
  localparam logic [PH_W-1:0]  PH_MAX   = '1;

  logic [SUB_W-1:0] sub_q, sub_d;
  logic [PH_W-1:0]  phase_q, phase_d;
  logic             boot_q, boot_d;
  logic             last_cyc, to_zero;

  always_comb begin
    last_cyc = (sub_q == SUB_LAST);
    to_zero  = last_cyc && (early_adv || (phase_q == PH_MAX));
    sub_d    = last_cyc ? '0 : sub_q + 1'b1;
    if (to_zero)       phase_d = '0;
    else if (last_cyc) phase_d = phase_q + 1'b1;
    else               phase_d = phase_q;
    boot_d = boot_q && !(to_zero && boot_release);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sub_q   <= '0;
      phase_q <= '0;
      boot_q  <= 1'b1;
    end else begin
      sub_q   <= sub_d;
      phase_q <= phase_d;
      boot_q  <= boot_d;
    end
  end

  assign phase     = phase_q;
  assign first_cyc = (sub_q == '0);
  assign boot_mode = boot_q;

  // R3
  ph_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sub_q != SUB_LAST) |=> $stable(phase_q));

  // R3
  ph_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (last_cyc && !early_adv && phase_q != PH_MAX) |=> (phase_q == $past(phase_q) + 1'b1));

  // R4
  early_ret_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (last_cyc && early_adv) |=> (phase_q == '0));

  // R12
  boot_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(boot_q) |-> ($past(boot_release) && phase_q == '0 && sub_q == '0));
endmodule

// File: rtl/ucw_bank_dec.sv
module ucw_bank_dec
  import ucw_pkg::*;
#(
  parameter logic [STB_W-1:0] USED = ALL_USED
) (
  input  logic [BANK_W-1:0] code,
  output logic [STB_W-1:0]  sel
);
  for (genvar i = 0; i < STB_W; i++) begin : g_stb
    if (USED[i]) begin : g_on
      assign sel[i] = (code == BANK_W'(i + 1));
    end else begin : g_off
      assign sel[i] = 1'b0;
    end
  end
endmodule

// File: rtl/ucw_ctrl_unit.sv
module ucw_ctrl_unit
  import ucw_pkg::*;
#(
  parameter int OPC_W         = 6,
  parameter int PH_W          = 4,
  parameter int CYC_PER_PHASE = 2,
  localparam int AW           = OPC_W + PH_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [OPC_W-1:0]  opcode_in,
  input  logic              boot_release,
  input  logic              wr_en,
  input  logic [AW-1:0]     wr_addr,
  input  logic [15:0]       wr_data,
  input  logic [1:0]        wr_be,
  output logic [PH_W-1:0]   phase_o,
  output logic [AW-1:0]     ucode_addr_o,
  output logic [15:0]       ctrl_word_o,
  output logic              boot_mode_o,
  output logic              early_adv_o,
  output logic              addr_src_pc_o,
  output logic              pc_incr_o,
  output logic              latch_pulse_o,
  output logic [6:0]        alu_sel_o,
  output logic [6:0]        sys_sel_o,
  output logic [6:0]        mem_sel_o,
  output logic [6:0]        reg_sel_o
);
  logic [PH_W-1:0]   phase;
  logic              first_cyc;
  logic              boot_mode;
  logic [OPC_W-1:0]  eff_opc;
  logic [AW-1:0]     rd_addr;
  logic [WORD_W-1:0] word;
  cword_t            cw;

  assign eff_opc = boot_mode ? '0 : opcode_in;
  assign rd_addr = {eff_opc, phase};

  ucw_store #(.AW(AW)) u_store (
    .clk     (clk),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .wr_be   (wr_be),
    .rd_addr (rd_addr),
    .rd_word (word)
  );

  assign cw = cword_t'(word);

  ucw_phase_seq #(.PH_W(PH_W), .CYC_PER_PHASE(CYC_PER_PHASE)) u_seq (
    .clk          (clk),
    .rst_n        (rst_n),
    .early_adv    (cw.early_adv),
    .boot_release (boot_release),
    .phase        (phase),
    .first_cyc    (first_cyc),
    .boot_mode    (boot_mode)
  );

  ucw_bank_dec #(.USED(ALL_USED)) u_alu (.code(cw.alu), .sel(alu_sel_o));
  ucw_bank_dec #(.USED(SYS_USED)) u_sys (.code(cw.sys), .sel(sys_sel_o));
  ucw_bank_dec #(.USED(ALL_USED)) u_mem (.code(cw.mem), .sel(mem_sel_o));
  ucw_bank_dec #(.USED(ALL_USED)) u_reg (.code(cw.rg),  .sel(reg_sel_o));

  assign phase_o       = phase;
  assign ucode_addr_o  = rd_addr;
  assign ctrl_word_o   = word;
  assign boot_mode_o   = boot_mode;
  assign early_adv_o   = cw.early_adv;
  assign addr_src_pc_o = cw.addr_src_pc;
  assign pc_incr_o     = cw.pc_incr;
  assign latch_pulse_o = cw.latch_req & first_cyc;

  // R7
  alu_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(alu_sel_o) && ((ctrl_word_o[11:9] != 3'd0) == (alu_sel_o != '0)));

  // R8
  sys_unused_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_word_o[8:6] == 3'd3 || ctrl_word_o[8:6] == 3'd7) |-> (sys_sel_o == '0));

  // R9
  mem_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(mem_sel_o));

  // R10
  reg_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(reg_sel_o) == ((ctrl_word_o[2:0] != 3'd0) ? 1 : 0));

  if (CYC_PER_PHASE > 1) begin : g_pulse_chk
    // R6
    pulse_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      latch_pulse_o |=> !latch_pulse_o);
  end
endmodule

// File: tb/ucw_ctrl_unit_test.sv
module ucw_ctrl_unit_test;
  localparam int OPC_W = 6;
  localparam int PH_W  = 4;
  localparam int CPP   = 2;
  localparam int AW    = OPC_W + PH_W;
  localparam int DEPTH = 1 << AW;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic [OPC_W-1:0] opcode_in = '0;
  logic             boot_release = 1'b0;
  logic             wr_en = 1'b0;
  logic [AW-1:0]    wr_addr = '0;
  logic [15:0]      wr_data = '0;
  logic [1:0]       wr_be = '0;
  logic [PH_W-1:0]  phase_o;
  logic [AW-1:0]    ucode_addr_o;
  logic [15:0]      ctrl_word_o;
  logic             boot_mode_o, early_adv_o, addr_src_pc_o, pc_incr_o, latch_pulse_o;
  logic [6:0]       alu_sel_o, sys_sel_o, mem_sel_o, reg_sel_o;

  ucw_ctrl_unit #(.OPC_W(OPC_W), .PH_W(PH_W), .CYC_PER_PHASE(CPP)) uut (
    .clk(clk), .rst_n(rst_n), .opcode_in(opcode_in), .boot_release(boot_release),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .wr_be(wr_be),
    .phase_o(phase_o), .ucode_addr_o(ucode_addr_o), .ctrl_word_o(ctrl_word_o),
    .boot_mode_o(boot_mode_o), .early_adv_o(early_adv_o), .addr_src_pc_o(addr_src_pc_o),
    .pc_incr_o(pc_incr_o), .latch_pulse_o(latch_pulse_o), .alu_sel_o(alu_sel_o),
    .sys_sel_o(sys_sel_o), .mem_sel_o(mem_sel_o), .reg_sel_o(reg_sel_o)
  );

  always #5 clk = ~clk;

  typedef struct {
    logic [AW-1:0]   addr;
    logic [PH_W-1:0] ph;
    logic [15:0]     w;
    logic            boot;
    logic            pulse;
  } exp_t;

  exp_t exp_q[$];
  int   n_vec = 0;
  int   n_bad = 0;
  bit   done = 0;

  // Reference model state
  logic [7:0] sh_hi [DEPTH];
  logic [7:0] sh_lo [DEPTH];
  int m_ph, m_sub;
  bit m_boot;

  function automatic logic [6:0] dec(input logic [2:0] c, input bit is_sys);
    if (c == 3'd0) return 7'd0;
    if (is_sys && (c == 3'd3 || c == 3'd7)) return 7'd0;
    return 7'd1 << (c - 3'd1);
  endfunction

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] expv);
    if (act !== expv) begin
      n_bad++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", req, what, act, expv, $time);
    end
  endtask

  // Monitor: compare each queued expectation mid-cycle
  always @(negedge clk) begin
    if (exp_q.size() > 0) begin
      exp_t e;
      e = exp_q.pop_front();
      n_vec++;
      chk("R2",  "ucode_addr",  32'(ucode_addr_o), 32'(e.addr));
      chk("R1",  "ctrl_word",   32'(ctrl_word_o),  32'(e.w));
      chk("R3",  "phase",       32'(phase_o),      32'(e.ph));
      chk("R11", "boot_mode",   32'(boot_mode_o),  32'(e.boot));
      chk("R4",  "early_adv",   32'(early_adv_o),  32'(e.w[15]));
      chk("R5",  "addr_src_pc", 32'(addr_src_pc_o), 32'(e.w[14]));
      chk("R5",  "pc_incr",     32'(pc_incr_o),    32'(e.w[13]));
      chk("R6",  "latch_pulse", 32'(latch_pulse_o), 32'(e.pulse));
      chk("R7",  "alu_sel",     32'(alu_sel_o),    32'(dec(e.w[11:9], 0)));
      chk("R8",  "sys_sel",     32'(sys_sel_o),    32'(dec(e.w[8:6], 1)));
      chk("R9",  "mem_sel",     32'(mem_sel_o),    32'(dec(e.w[5:3], 0)));
      chk("R10", "reg_sel",     32'(reg_sel_o),    32'(dec(e.w[2:0], 0)));
    end
  end

  // Driver: one clock of stimulus; pushes the expectation for this cycle
  task automatic cycle(input logic [OPC_W-1:0] op, input bit rel,
                       input bit we, input logic [AW-1:0] wa,
                       input logic [15:0] wd, input logic [1:0] be);
    exp_t e;
    logic [AW-1:0] a;
    logic [15:0] w;
    bit last, zero;
    opcode_in = op; boot_release = rel;
    wr_en = we; wr_addr = wa; wr_data = wd; wr_be = be;
    a = {(m_boot ? {OPC_W{1'b0}} : op), PH_W'(m_ph)};
    w = {sh_hi[a], sh_lo[a]};
    e.addr = a; e.ph = PH_W'(m_ph); e.w = w; e.boot = m_boot;
    e.pulse = w[12] && (m_sub == 0);
    exp_q.push_back(e);
    @(posedge clk);
    if (we && be[1]) sh_hi[wa] = wd[15:8];
    if (we && be[0]) sh_lo[wa] = wd[7:0];
    if (rst_n) begin
      last = (m_sub == CPP - 1);
      zero = last && (w[15] || m_ph == (1 << PH_W) - 1);
      if (zero && rel) m_boot = 0;
      m_sub = last ? 0 : m_sub + 1;
      if (zero) m_ph = 0;
      else if (last) m_ph = m_ph + 1;
    end
    #1;
  endtask

  task automatic run(input logic [OPC_W-1:0] op, input bit rel, input int n);
    for (int i = 0; i < n; i++) cycle(op, rel, 0, '0, '0, 2'b00);
  endtask

  task automatic put(input logic [AW-1:0] wa, input logic [15:0] wd, input logic [1:0] be);
    cycle(opcode_in, 0, 1, wa, wd, be);
  endtask

  task automatic set_rst(input bit v);
    rst_n = v;
    if (!v) begin m_ph = 0; m_sub = 0; m_boot = 1; end
  endtask

  initial begin
    set_rst(0);
    @(posedge clk); #1;
    // R13: reset state is checked on every cycle of the fill below
    for (int i = 0; i < DEPTH; i++) put(AW'(i), 16'h0000, 2'b11);
    // Boot routine (opcode 0)
    put(AW'(0),  16'h1040, 2'b11);
    put(AW'(1),  16'h0411, 2'b11);
    put(AW'(7),  16'h4180, 2'b11);
    put(AW'(15), 16'h2000, 2'b11);
    // Opcode 5: every bank code across the phases, latch on upper half (R7..R10)
    for (int p = 0; p < 16; p++)
      put({6'd5, 4'(p)}, 16'(((p & 7) * 16'h0249) | ((p >> 3) << 12)), 2'b11);
    // Opcode 3: early return at phase 2 (R4); R1 full word 0xBEEF
    put({6'd3, 4'd0}, 16'h5AB3, 2'b11);
    put({6'd3, 4'd1}, 16'h71C6, 2'b11);
    put({6'd3, 4'd2}, 16'hBEEF, 2'b11);

    set_rst(1);
    run(6'd5, 0, 8);          // R11: opcode forced to zero in boot
    run(6'd5, 1, 4);          // R12: mid-pass release ignored
    run(6'd5, 0, 10);
    run(6'd5, 1, 12);         // R12: release at the wrap from 15 to 0
    run(6'd5, 0, 36);         // R3 wrap, R6, R7..R10
    run(6'd3, 0, 12);         // R4 early return
    put({6'd3, 4'd1}, 16'hFF12, 2'b01);   // R1: low half only -> 0x7112
    put({6'd3, 4'd2}, 16'h0A99, 2'b10);   // R1: high half only -> 0x0AEF
    run(6'd3, 0, 40);

    set_rst(0);               // R13: asynchronous reset mid-run
    put(AW'(4), 16'h9000, 2'b11);
    run(6'd3, 0, 2);
    set_rst(1);
    run(6'd3, 0, 6);
    run(6'd3, 1, 6);          // R12 + R4: release meets early return at boot phase 4
    run(6'd3, 0, 16);
    @(posedge clk); #1;
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule